// File: doc/BRIEF.md
# Two-Mode Burst Address Sequencer

This block generates the low-order address bits for a four-beat burst in a synchronous memory. A load cycle captures a start address from the external bus; each continue cycle after that moves the burst one beat forward. The upper address bits are captured with the start address and are presented unchanged for the rest of the burst.

The order of the offsets depends on an order-select input, which is sampled only at the load cycle. When the select is high, the order is interleaved: the start offset XOR the beat number. When the select is low, the order is linear: the start offset plus the beat number, wrapping within the four-beat group. A low clock enable inserts a wait state, and the burst position holds.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, the beat counter is zero, `beat_ofs` reads 00 and `addr_out` reads all zeros. The captured order resets to interleaved.
- R2: A load cycle takes effect at a rising clock edge with `clk_en`=1 and `cont_nload`=0. After that edge, `beat_ofs` equals the low two bits of `addr_in` that were sampled at the edge, and the beat number restarts at 0.
- R3: With linear order captured (`order_sel`=0 at load), each continue cycle (`clk_en`=1, `cont_nload`=1) gives `beat_ofs` = (start + beat) mod 4. For example, start 01 gives 01,10,11,00.
- R4: With interleaved order captured (`order_sel`=1 at load), each continue cycle gives `beat_ofs` = start XOR beat. For example, start 01 gives 01,00,11,10, and start 10 gives 10,11,00,01.
- R5: A change on `order_sel` outside a load cycle has no effect on the offset sequence of the burst in progress.
- R6: When `clk_en`=0, `beat_ofs` and `addr_out` hold their values whatever the other inputs do.
- R7: A continue cycle after the fourth beat wraps the beat number to 0, so the offset returns to the start offset.
- R8: `addr_out` is {captured upper bits, `beat_ofs`}. The upper bits come from `addr_in` at the load cycle and do not change on continue cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; 0 inserts a wait state |
| cont_nload | input | 1 | 0 = load start address, 1 = continue burst |
| addr_in | input | ADDR_W (8) | External address; sampled on load |
| order_sel | input | 1 | 1 = interleaved, 0 = linear; sampled on load |
| addr_out | output | ADDR_W (8) | Captured upper bits joined with the current offset |
| beat_ofs | output | OFS_W (2) | Current burst offset |

## Verification
The assertions check several properties on every cycle: the load capture, the per-step relation in each order (a linear step adds one, and an interleaved step changes the offset by the same bits as the beat counter), the freeze during wait states, the freeze of the upper bits and the captured order during continue cycles, and the counter wrap. The bench's scenarios are needed for the rest. They show the full four-beat sequences from chosen start offsets, the return to the start offset after the fourth beat, and that toggling the order select in the middle of a burst changes nothing. Long random runs that mix loads, continues and wait states are compared against an independent bench model.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_ev,
  input  logic         step_ev,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load_ev) cnt <= '0;
    else if (step_ev) cnt <= cnt + W'(1);
  end

  // R2: a load restarts the beat number
  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> cnt == '0);
  // R7: a step advances by one and wraps past the last beat
  p_cnt_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !load_ev && cnt == {W{1'b1}}) |=> cnt == '0);
  // R6: no event, no movement
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !step_ev) |=> $stable(cnt));
endmodule

// File: rtl/bseq_burst_reg.sv
module bseq_burst_reg
  import bseq_pkg::*;
#(
  parameter int OFS_W = 2,
  parameter int UP_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_ev,
  input  logic [OFS_W-1:0] start_in,
  input  logic [UP_W-1:0]  upper_in,
  input  logic             order_in,
  output logic [OFS_W-1:0] start_q,
  output logic [UP_W-1:0]  upper_q,
  output order_e           order_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      upper_q <= '0;
      order_q <= ORD_INTERLEAVE;
    end else if (load_ev) begin
      start_q <= start_in;
      upper_q <= upper_in;
      order_q <= order_e'(order_in);
    end
  end

  // R5, R8: the captured burst context is frozen between loads
  p_ctx_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> ($stable(order_q) && $stable(upper_q) && $stable(start_q)));
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import bseq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] start,
  input  logic [W-1:0] beat,
  input  order_e       order,
  output logic [W-1:0] ofs
);
  function automatic logic [W-1:0] lin_ofs(logic [W-1:0] s, logic [W-1:0] b);
    return s + b;
  endfunction

  logic [W-1:0] ilv_v;
  logic [W-1:0] lin_v;

  // interleaved order: each offset bit flips with the matching beat bit
  for (genvar i = 0; i < W; i++) begin : g_ilv_bit
    assign ilv_v[i] = start[i] ^ beat[i];
  end

  assign lin_v = lin_ofs(start, beat);

  always_comb begin
    case (order)
      ORD_LINEAR: ofs = lin_v;
      default:    ofs = ilv_v;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              cont_nload,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic [OFS_W-1:0]  beat_ofs
);
  localparam int UP_W = ADDR_W - OFS_W;

  logic             load_ev;
  logic             step_ev;
  logic [OFS_W-1:0] cnt;
  logic [OFS_W-1:0] start_q;
  logic [UP_W-1:0]  upper_q;
  order_e           order_q;

  assign load_ev = clk_en && !cont_nload;
  assign step_ev = clk_en &&  cont_nload;

  bseq_beat_ctr #(.W(OFS_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ev (load_ev),
    .step_ev (step_ev),
    .cnt     (cnt)
  );

  bseq_burst_reg #(.OFS_W(OFS_W), .UP_W(UP_W)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ev  (load_ev),
    .start_in (addr_in[OFS_W-1:0]),
    .upper_in (addr_in[ADDR_W-1:OFS_W]),
    .order_in (order_sel),
    .start_q  (start_q),
    .upper_q  (upper_q),
    .order_q  (order_q)
  );

  bseq_order_map #(.W(OFS_W)) u_map (
    .start (start_q),
    .beat  (cnt),
    .order (order_q),
    .ofs   (beat_ofs)
  );

  assign addr_out = {upper_q, beat_ofs};

  // R1: reset state at the ports
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (beat_ofs == '0 && addr_out == '0));
  // R2: the loaded offset appears after the load edge
  p_load_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> beat_ofs == $past(addr_in[OFS_W-1:0]));
  // R3: a linear step adds one, modulo the burst length
  p_lin_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && order_q == ORD_LINEAR) |=> beat_ofs == $past(beat_ofs) + OFS_W'(1));
  // R4: an interleaved step flips exactly the bits the beat number flips
  p_ilv_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && order_q == ORD_INTERLEAVE) |=> (beat_ofs ^ $past(beat_ofs)) == (cnt ^ $past(cnt)));
  // R6: a wait state freezes the outputs
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(beat_ofs) && $stable(addr_out)));
  // R8: upper bits do not move on continue cycles
  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> addr_out[ADDR_W-1:OFS_W] == $past(addr_out[ADDR_W-1:OFS_W]));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       cont_nload = 1'b1;
  logic [7:0] addr_in = 8'h00;
  logic       order_sel = 1'b1;
  logic [7:0] addr_out;
  logic [1:0] beat_ofs;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model
  logic [1:0] m_start = 2'b00;
  int         m_beat = 0;
  logic       m_ilv = 1'b1;
  logic [5:0] m_up = 6'h00;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cont_nload(cont_nload),
    .addr_in(addr_in), .order_sel(order_sel), .addr_out(addr_out), .beat_ofs(beat_ofs)
  );

  always #10 clk = ~clk;

  function automatic logic [1:0] exp_ofs();
    logic [1:0] b;
    logic [1:0] r;
    b = 2'(m_beat);
    if (m_ilv) begin
      for (int i = 0; i < 2; i++) r[i] = (m_start[i] != b[i]);
    end else begin
      r = 2'((int'(m_start) + m_beat) % 4);
    end
    return r;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] expv, input string req);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_model(input string req);
    check({6'h00, beat_ofs}, {6'h00, exp_ofs()}, req);
    check(addr_out, {m_up, exp_ofs()}, req);
  endtask

  // drive after a falling edge, let one rising edge act, compare at the next falling edge
  task automatic cyc(input logic ce, input logic cont, input logic [7:0] a, input logic sel);
    clk_en = ce; cont_nload = cont; addr_in = a; order_sel = sel;
    @(posedge clk);
    if (rst_n && ce) begin
      if (!cont) begin
        m_start = a[1:0]; m_up = a[7:2]; m_ilv = sel; m_beat = 0;
      end else begin
        m_beat = (m_beat + 1) % 4;
      end
    end
    @(negedge clk);
  endtask

  task automatic burst_seq(input logic [7:0] a, input logic sel,
                           input logic [1:0] e0, input logic [1:0] e1,
                           input logic [1:0] e2, input logic [1:0] e3, input string req);
    logic [1:0] ev [4];
    ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
    cyc(1'b1, 1'b0, a, sel);
    check({6'h00, beat_ofs}, {6'h00, ev[0]}, "R2");
    for (int k = 1; k < 4; k++) begin
      cyc(1'b1, 1'b1, 8'h00, sel);
      check({6'h00, beat_ofs}, {6'h00, ev[k]}, req);
    end
    // R7: one more continue wraps back to the start offset
    cyc(1'b1, 1'b1, 8'h00, sel);
    check({6'h00, beat_ofs}, {6'h00, ev[0]}, "R7");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(addr_out, 8'h00, "R1");
    check({6'h00, beat_ofs}, 8'h00, "R1");
    cyc(1'b1, 1'b1, 8'hFF, 1'b0);
    check(addr_out, 8'h00, "R1");
    rst_n = 1'b1;

    // R3: linear sequences
    burst_seq(8'h41, 1'b0, 2'b01, 2'b10, 2'b11, 2'b00, "R3");
    burst_seq(8'h43, 1'b0, 2'b11, 2'b00, 2'b01, 2'b10, "R3");
    // R4: interleaved sequences
    burst_seq(8'h81, 1'b1, 2'b01, 2'b00, 2'b11, 2'b10, "R4");
    burst_seq(8'h82, 1'b1, 2'b10, 2'b11, 2'b00, 2'b01, "R4");
    burst_seq(8'h83, 1'b1, 2'b11, 2'b10, 2'b01, 2'b00, "R4");

    // R5: order select toggled mid-burst is ignored
    cyc(1'b1, 1'b0, 8'h21, 1'b0);
    cyc(1'b1, 1'b1, 8'h00, 1'b1);
    check({6'h00, beat_ofs}, 8'h02, "R5");
    cyc(1'b1, 1'b1, 8'h00, 1'b1);
    check({6'h00, beat_ofs}, 8'h03, "R5");

    // R6: wait states hold, even with load requested
    cyc(1'b0, 1'b0, 8'hEE, 1'b1);
    check(addr_out, 8'h23, "R6");
    cyc(1'b0, 1'b1, 8'h11, 1'b0);
    check(addr_out, 8'h23, "R6");
    cyc(1'b1, 1'b1, 8'h00, 1'b0);
    check(addr_out, 8'h20, "R6");

    // R8: upper bits ignore the bus during continues
    cyc(1'b1, 1'b0, 8'hA6, 1'b1);
    cyc(1'b1, 1'b1, 8'h5F, 1'b0);
    check(addr_out, 8'hA7, "R8");

    // random mix checked against the model (R2..R8)
    for (int n = 0; n < 2000; n++) begin
      logic ce, cont, sel;
      logic [7:0] a;
      ce   = ($urandom_range(0, 9) != 0);
      cont = ($urandom_range(0, 4) != 0);
      sel  = 1'($urandom_range(0, 1));
      a    = 8'($urandom_range(0, 255));
      cyc(ce, cont, a, sel);
      check_model("R3/R4 random");
    end

    // R1: reset mid-burst
    rst_n = 1'b0;
    #1;
    check(addr_out, 8'h00, "R1");
    m_start = 2'b00; m_beat = 0; m_ilv = 1'b1; m_up = 6'h00;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b1, 1'b1, 8'h00, 1'b0);
    check({6'h00, beat_ofs}, 8'h01, "R1");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule